// File: doc/BRIEF.md
# Receive Packet Framing Controller

This block sits behind sync-word detection in a packet receiver and takes the decoded byte stream one byte per strobe. It walks each packet through its fields: a fixed number of header bytes, an optional in-packet length byte, the payload, and an optional two-byte checksum. For every byte it decides whether the byte is written to the receive FIFO or dropped. The header comparison and the checksum arithmetic are done elsewhere. This block only samples their pass flags at the right byte.

When a packet ends it sets sticky status bits for a good packet or a checksum failure. Each status bit drives a shared interrupt line only when its enable is set. Two things follow the end of a packet. In normal mode a good packet ends receive mode. Otherwise the block asks the front end to go back to preamble search and stays in receive mode. The payload length comes either from a programmed value or from the length byte inside the packet. When the handler is disabled, the block forwards raw bytes and does no framing.

Top module: `rx_frame_ctrl`

## Requirements
- R1: After reset `rx_active`, `fifo_we`, `hunt_preamble`, `stat_valid`, `stat_crc_err` and `irq` are 0 and `rx_len` is 0.
- R2: With `cfg_ph_en`=0, every byte strobed while `rx_active`=1 is written to the FIFO unchanged. No status bit is set and `rx_active` is not cleared.
- R3: With `cfg_fix_len`=1, no length byte is expected. The payload is exactly `cfg_pk_len` bytes and starts right after the last header byte. `rx_len` keeps its value.
- R4: With `cfg_fix_len`=0, the byte that follows the last header byte is the length. It is stored in `rx_len` and sets the payload byte count. `cfg_pk_len` is then ignored.
- R5: With `cfg_crc_en`=1, the two bytes after the payload are the checksum and are never written. `crc_match` is sampled on the second of them. With `cfg_crc_en`=0, the packet ends on its last payload byte and counts as good.
- R6: When `hdr_pass`=0 on the last header byte, all later bytes of that packet are ignored. The block pulses `hunt_preamble`, keeps `rx_active`=1 and sets no status.
- R7: With `cfg_multi`=0, only payload bytes reach the FIFO. A good packet sets `stat_valid`, clears `rx_active` and gives no `hunt_preamble` pulse.
- R8: With `cfg_multi`=1, header bytes are written as they arrive, even when the header then fails, and so is the length byte. A good packet keeps `rx_active`=1 and pulses `hunt_preamble`.
- R9: When `crc_match`=0 on the last checksum byte, `stat_crc_err` is set, `stat_valid` stays 0, `rx_active` stays 1 and `hunt_preamble` pulses.
- R10: `stat_valid` and `stat_crc_err` stay set until a `stat_clr` pulse. A new event in the same cycle as `stat_clr` wins.
- R11: `irq` = (`stat_valid` AND `irq_en_valid`) OR (`stat_crc_err` AND `irq_en_crc`).
- R12: A payload length of 0 goes straight to the checksum bytes, or ends the packet as good when the checksum is disabled.
- R13: Each accepted byte gives at most one FIFO write. `fifo_we` is high exactly one cycle after the strobe of the byte it carries, with that byte on `fifo_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_go | input | 1 | Pulse: enter receive mode |
| sync_det | input | 1 | Pulse: sync word found, a packet starts |
| byte_vld | input | 1 | Decoded byte strobe |
| byte_data | input | 8 | Decoded byte |
| hdr_pass | input | 1 | Header check result, sampled on the last header byte |
| crc_match | input | 1 | Checksum result, sampled on the last checksum byte |
| cfg_ph_en | input | 1 | Packet handler enable |
| cfg_fix_len | input | 1 | 1: programmed length, 0: length byte in the packet |
| cfg_pk_len | input | 8 | Programmed payload length |
| cfg_multi | input | 1 | Multi-packet mode |
| cfg_crc_en | input | 1 | Checksum field present |
| irq_en_valid | input | 1 | Interrupt enable for a good packet |
| irq_en_crc | input | 1 | Interrupt enable for a checksum error |
| stat_clr | input | 1 | Pulse: clear both status bits |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| rx_len | output | 8 | Last received length byte |
| rx_active | output | 1 | Block is in receive mode |
| hunt_preamble | output | 1 | Pulse: go back to preamble search |
| stat_valid | output | 1 | Sticky good-packet status |
| stat_crc_err | output | 1 | Sticky checksum-error status |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check the following on every cycle:
- every FIFO write follows a byte strobe;
- status bits hold until cleared;
- the interrupt is only raised when a status bit is set;
- a good packet and a checksum error never end the same packet;
- the mode-dependent exit after a good packet, a failed header or a failed checksum is followed.

Whether the right bytes reach the FIFO in the right order can only be shown by the bench's packet scenarios. The same holds for whether the length comes from the right source, for zero-length packets and for raw forwarding with the handler off. The bench compares the FIFO contents and the exit state with a model built from the configuration of each packet.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned CRC_BYTES = 2;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_HDR,
    ST_LEN,
    ST_PAY,
    ST_CRC
  } rxf_state_e;

  // Field that follows a known payload length.
  function automatic rxf_state_e after_len(input logic [7:0] plen, input logic crc_on);
    if (plen != 8'd0) return ST_PAY;
    if (crc_on)       return ST_CRC;
    return ST_HUNT;
  endfunction

  // Field that follows the header once it has passed.
  function automatic rxf_state_e after_hdr(input logic fix, input logic [7:0] pk_len,
                                           input logic crc_on);
    if (fix) return after_len(pk_len, crc_on);
    return ST_LEN;
  endfunction
endpackage

// File: rtl/rxf_seq.sv
module rxf_seq
  import rxf_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 2,
  parameter int unsigned DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_go,
  input  logic          sync_det,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          hdr_pass,
  input  logic          crc_match,
  input  logic          cfg_ph_en,
  input  logic          cfg_fix_len,
  input  logic [DW-1:0] cfg_pk_len,
  input  logic          cfg_multi,
  input  logic          cfg_crc_en,
  output logic          take,
  output logic          rx_active,
  output logic          hunt_pulse,
  output logic [DW-1:0] rx_len,
  output logic          ev_pkt_ok,
  output logic          ev_crc_bad,
  output logic          ev_hdr_bad
);
  localparam logic [DW-1:0] HDR_LAST = DW'((HDR_BYTES == 0) ? 0 : HDR_BYTES - 1);
  localparam logic [DW-1:0] CRC_LAST = DW'(CRC_BYTES - 1);

  rxf_state_e    st, st_n;
  logic [DW-1:0] cnt, cnt_n;
  logic [DW-1:0] plen, plen_n;
  logic          cap_len;

  always_comb begin
    st_n       = st;
    cnt_n      = cnt;
    plen_n     = plen;
    take       = 1'b0;
    cap_len    = 1'b0;
    ev_pkt_ok  = 1'b0;
    ev_crc_bad = 1'b0;
    ev_hdr_bad = 1'b0;
    if (!cfg_ph_en) begin
      st_n  = ST_HUNT;
      cnt_n = '0;
      take  = rx_active && byte_vld;
    end else if (rx_active) begin
      unique case (st)
        ST_HUNT: begin
          if (sync_det) begin
            cnt_n = '0;
            if (HDR_BYTES == 0) begin
              plen_n    = cfg_pk_len;
              st_n      = after_hdr(cfg_fix_len, cfg_pk_len, cfg_crc_en);
              ev_pkt_ok = (st_n == ST_HUNT);
            end else begin
              st_n = ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (byte_vld) begin
            take  = cfg_multi;
            cnt_n = cnt + 1'b1;
            if (cnt == HDR_LAST) begin
              cnt_n = '0;
              if (!hdr_pass) begin
                ev_hdr_bad = 1'b1;
                st_n       = ST_HUNT;
              end else begin
                plen_n    = cfg_pk_len;
                st_n      = after_hdr(cfg_fix_len, cfg_pk_len, cfg_crc_en);
                ev_pkt_ok = (st_n == ST_HUNT);
              end
            end
          end
        end
        ST_LEN: begin
          if (byte_vld) begin
            take      = cfg_multi;
            cap_len   = 1'b1;
            plen_n    = byte_data;
            cnt_n     = '0;
            st_n      = after_len(byte_data, cfg_crc_en);
            ev_pkt_ok = (st_n == ST_HUNT);
          end
        end
        ST_PAY: begin
          if (byte_vld) begin
            take  = 1'b1;
            cnt_n = cnt + 1'b1;
            if (cnt == plen - 1'b1) begin
              cnt_n     = '0;
              st_n      = cfg_crc_en ? ST_CRC : ST_HUNT;
              ev_pkt_ok = !cfg_crc_en;
            end
          end
        end
        ST_CRC: begin
          if (byte_vld) begin
            cnt_n = cnt + 1'b1;
            if (cnt == CRC_LAST) begin
              cnt_n      = '0;
              st_n       = ST_HUNT;
              ev_pkt_ok  = crc_match;
              ev_crc_bad = !crc_match;
            end
          end
        end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_HUNT;
      cnt        <= '0;
      plen       <= '0;
      rx_len     <= '0;
      rx_active  <= 1'b0;
      hunt_pulse <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      plen       <= plen_n;
      hunt_pulse <= ev_hdr_bad || ev_crc_bad || (ev_pkt_ok && cfg_multi);
      if (cap_len) rx_len <= byte_data;
      if (rx_go)                       rx_active <= 1'b1;
      else if (ev_pkt_ok && !cfg_multi) rx_active <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_route.sv
module rxf_route #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] byte_data,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      fifo_we <= take;
      if (take) fifo_wdata <= byte_data;
    end
  end
endmodule

// File: rtl/rxf_status.sv
module rxf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_pkt_ok,
  input  logic ev_crc_bad,
  input  logic stat_clr,
  input  logic irq_en_valid,
  input  logic irq_en_crc,
  output logic stat_valid,
  output logic stat_crc_err,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid   <= 1'b0;
      stat_crc_err <= 1'b0;
    end else begin
      if (ev_pkt_ok)     stat_valid <= 1'b1;
      else if (stat_clr) stat_valid <= 1'b0;
      if (ev_crc_bad)    stat_crc_err <= 1'b1;
      else if (stat_clr) stat_crc_err <= 1'b0;
    end
  end

  assign irq = (stat_valid && irq_en_valid) || (stat_crc_err && irq_en_crc);
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl #(
  parameter int unsigned HDR_BYTES = 2,
  parameter int unsigned DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_go,
  input  logic          sync_det,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          hdr_pass,
  input  logic          crc_match,
  input  logic          cfg_ph_en,
  input  logic          cfg_fix_len,
  input  logic [DW-1:0] cfg_pk_len,
  input  logic          cfg_multi,
  input  logic          cfg_crc_en,
  input  logic          irq_en_valid,
  input  logic          irq_en_crc,
  input  logic          stat_clr,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_wdata,
  output logic [DW-1:0] rx_len,
  output logic          rx_active,
  output logic          hunt_preamble,
  output logic          stat_valid,
  output logic          stat_crc_err,
  output logic          irq
);
  logic take;
  logic ev_pkt_ok;
  logic ev_crc_bad;
  logic ev_hdr_bad;

  rxf_seq #(.HDR_BYTES(HDR_BYTES), .DW(DW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_go      (rx_go),
    .sync_det   (sync_det),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .hdr_pass   (hdr_pass),
    .crc_match  (crc_match),
    .cfg_ph_en  (cfg_ph_en),
    .cfg_fix_len(cfg_fix_len),
    .cfg_pk_len (cfg_pk_len),
    .cfg_multi  (cfg_multi),
    .cfg_crc_en (cfg_crc_en),
    .take       (take),
    .rx_active  (rx_active),
    .hunt_pulse (hunt_preamble),
    .rx_len     (rx_len),
    .ev_pkt_ok  (ev_pkt_ok),
    .ev_crc_bad (ev_crc_bad),
    .ev_hdr_bad (ev_hdr_bad)
  );

  rxf_route #(.DW(DW)) route_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .byte_data (byte_data),
    .fifo_we   (fifo_we),
    .fifo_wdata(fifo_wdata)
  );

  rxf_status status_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_pkt_ok   (ev_pkt_ok),
    .ev_crc_bad  (ev_crc_bad),
    .stat_clr    (stat_clr),
    .irq_en_valid(irq_en_valid),
    .irq_en_crc  (irq_en_crc),
    .stat_valid  (stat_valid),
    .stat_crc_err(stat_crc_err),
    .irq         (irq)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_go,
  input logic byte_vld,
  input logic fifo_we,
  input logic stat_valid,
  input logic stat_crc_err,
  input logic stat_clr,
  input logic irq,
  input logic rx_active,
  input logic hunt_preamble,
  input logic cfg_ph_en,
  input logic cfg_multi,
  input logic ev_pkt_ok,
  input logic ev_crc_bad,
  input logic ev_hdr_bad
);
  assert_write_follows_byte_R13: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(byte_vld));

  assert_valid_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !stat_clr) |=> stat_valid);

  assert_crcerr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_crc_err && !stat_clr) |=> stat_crc_err);

  assert_irq_needs_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_valid || stat_crc_err));

  assert_no_valid_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ph_en |-> !(ev_pkt_ok || ev_crc_bad || ev_hdr_bad));

  assert_ok_xor_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_pkt_ok && ev_crc_bad));

  assert_hdr_fail_hunt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr_bad |=> (hunt_preamble && rx_active));

  assert_normal_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pkt_ok && !cfg_multi && !rx_go) |=> (!rx_active && !hunt_preamble));

  assert_multi_stay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pkt_ok && cfg_multi) |=> (rx_active && hunt_preamble));

  assert_crc_fail_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc_bad |=> (stat_crc_err && rx_active && hunt_preamble));
endmodule

bind rx_frame_ctrl rxf_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_go        (rx_go),
  .byte_vld     (byte_vld),
  .fifo_we      (fifo_we),
  .stat_valid   (stat_valid),
  .stat_crc_err (stat_crc_err),
  .stat_clr     (stat_clr),
  .irq          (irq),
  .rx_active    (rx_active),
  .hunt_preamble(hunt_preamble),
  .cfg_ph_en    (cfg_ph_en),
  .cfg_multi    (cfg_multi),
  .ev_pkt_ok    (ev_pkt_ok),
  .ev_crc_bad   (ev_crc_bad),
  .ev_hdr_bad   (ev_hdr_bad)
);

// File: tb/rx_frame_ctrl_tb.sv
module rx_frame_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NHDR       = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_go = 1'b0, sync_det = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic       hdr_pass = 1'b1, crc_match = 1'b1;
  logic       cfg_ph_en = 1'b1, cfg_fix_len = 1'b0, cfg_multi = 1'b0, cfg_crc_en = 1'b0;
  logic [7:0] cfg_pk_len = '0;
  logic       irq_en_valid = 1'b0, irq_en_crc = 1'b0, stat_clr = 1'b0;
  logic       fifo_we, rx_active, hunt_preamble, stat_valid, stat_crc_err, irq;
  logic [7:0] fifo_wdata, rx_len;

  int n_chk = 0, n_bad = 0, hunt_cnt = 0, cyc = 0;
  logic [7:0] gotq[$];
  logic [7:0] expq[$];
  logic [7:0] exp_len = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_ctrl #(.HDR_BYTES(NHDR), .DW(8)) dut_i (.*);

  always @(negedge clk) begin
    cyc++;
    if (rst_n && fifo_we) gotq.push_back(fifo_wdata);
    if (rst_n && hunt_preamble) hunt_cnt++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got cycle %0d expected < 150000", cyc);
    summary();
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_irq(logic v, logic c, logic ev, logic ec);
    return int'((v & ev) | (c & ec));
  endfunction

  task automatic send(logic [7:0] b);
    int gap = $urandom % 3;
    repeat (gap) @(negedge clk);
    byte_vld = 1'b1; byte_data = b;
    @(negedge clk);
    byte_vld = 1'b0; byte_data = $urandom;
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
  endtask

  // One packet under a given configuration, then compare with the model.
  task automatic run_pkt(string tag, logic ph, logic fix, int len, logic multi, logic crc,
                         logic cm, logic hp, logic ev, logic ec);
    logic ev_ok, ev_bad, exp_act;
    int   hunt0, exp_hunt;
    logic [7:0] b;
    cfg_ph_en = ph; cfg_fix_len = fix; cfg_multi = multi; cfg_crc_en = crc;
    cfg_pk_len = fix ? 8'(len) : 8'($urandom);
    crc_match = cm; hdr_pass = hp; irq_en_valid = ev; irq_en_crc = ec;
    pulse_clr();
    if (!rx_active) begin rx_go = 1'b1; @(negedge clk); rx_go = 1'b0; end
    gotq.delete(); expq.delete();
    hunt0 = hunt_cnt;
    sync_det = 1'b1; @(negedge clk); sync_det = 1'b0;
    for (int i = 0; i < NHDR; i++) begin
      b = $urandom; send(b);
      if (!ph || multi) expq.push_back(b);
    end
    if (!fix) begin
      b = 8'(len); send(b);
      if (!ph || (hp && multi)) expq.push_back(b);
      if (ph && hp) exp_len = b;
    end
    for (int i = 0; i < len; i++) begin
      b = $urandom; send(b);
      if (!ph || hp) expq.push_back(b);
    end
    if (crc) for (int i = 0; i < 2; i++) begin
      b = $urandom; send(b);
      if (!ph) expq.push_back(b);
    end
    repeat (3) @(negedge clk);
    ev_ok  = ph && hp && (!crc || cm);
    ev_bad = ph && hp && crc && !cm;
    exp_act  = !(ev_ok && !multi);
    exp_hunt = (ph && (!hp || ev_bad || (ev_ok && multi))) ? 1 : 0;
    chk({tag, " R7/R8 fifo count"}, gotq.size(), expq.size());
    if (gotq.size() == expq.size())
      for (int i = 0; i < expq.size(); i++)
        chk({tag, " R13 fifo byte"}, gotq[i], expq[i]);
    chk({tag, " R5 stat_valid"}, stat_valid, ev_ok);
    chk({tag, " R9 stat_crc_err"}, stat_crc_err, ev_bad);
    chk({tag, " R11 irq"}, irq, exp_irq(ev_ok, ev_bad, ev, ec));
    chk({tag, " R6 rx_active"}, rx_active, exp_act);
    chk({tag, " R8 hunt pulses"}, hunt_cnt - hunt0, exp_hunt);
    chk({tag, " R4 rx_len"}, rx_len, exp_len);
    repeat (4) @(negedge clk);
    chk({tag, " R10 sticky valid"}, stat_valid, ev_ok);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 rx_active", rx_active, 0);
    chk("R1 fifo_we", fifo_we, 0);
    chk("R1 status", {stat_valid, stat_crc_err, irq}, 0);
    chk("R1 rx_len", rx_len, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {rx_active, hunt_preamble, fifo_we}, 0);

    run_pkt("R3 fixed len", 1, 1, 3, 0, 0, 1, 1, 1, 1);
    run_pkt("R4 var len crc", 1, 0, 5, 0, 1, 1, 1, 1, 0);
    run_pkt("R12 zero crc", 1, 0, 0, 0, 1, 1, 1, 1, 1);
    run_pkt("R12 zero nocrc", 1, 0, 0, 1, 0, 1, 1, 0, 1);
    run_pkt("R12 fixed zero", 1, 1, 0, 0, 1, 0, 1, 0, 1);
    run_pkt("R6 hdr fail", 1, 0, 4, 0, 1, 1, 0, 1, 1);
    run_pkt("R8 hdr fail multi", 1, 1, 4, 1, 0, 1, 0, 1, 1);
    run_pkt("R9 crc bad", 1, 0, 6, 0, 1, 0, 1, 0, 1);
    run_pkt("R8 multi good", 1, 0, 3, 1, 1, 1, 1, 1, 0);
    run_pkt("R2 raw", 0, 0, 4, 0, 1, 1, 1, 1, 1);

    pulse_clr();
    @(negedge clk);
    chk("R10 cleared", {stat_valid, stat_crc_err}, 0);

    for (int k = 0; k < 40; k++) begin
      logic ph, fix, mu, cr, cm, hp;
      int len;
      ph  = ($urandom % 6) != 0;
      fix = $urandom;
      mu  = $urandom;
      cr  = $urandom;
      cm  = ($urandom % 4) != 0;
      hp  = ($urandom % 6) != 0;
      len = (($urandom % 5) == 0) ? 0 : 1 + ($urandom % 12);
      run_pkt("rand", ph, fix, len, mu, cr, cm, hp, 1'($urandom), 1'($urandom));
    end
    summary();
  end
endmodule